// File: doc/BRIEF.md
# Frame Window Address Translator

This block sits between an 8-bit microcontroller bus and the address port of a disc data buffer. The buffer is divided into numbered frames of 4 KB each. The controller selects a frame through a two-byte frame register. It then sees that frame, and the two frames that follow it, through three adjacent 4 KB windows in its own address space.

The frames that follow are taken inside a circular region bounded by a first-frame and a last-frame input. A step past the last frame lands back at the first, and the controller never sees this. Accesses below the windows go to flat buffer memory. A seven-bit page register supplies the upper address bits for those accesses.

Each access in a window or in the flat region produces a one-cycle memory request with a buffer address. Loads of the frame register are held back while a memory cycle is in flight.

Top module: `mfw_xlate`

## Requirements
- R1: After reset, both frame register bytes and the page register read back 0x00 and `mem_req` is low.
- R2: A write to the frame low byte (CPU address 0xFF00) only stages the byte. The committed frame number, and both readbacks, change only on a write to the high byte (0xFF01). That write commits {wdata[2:0], staged low byte} as the 11-bit frame.
- R3: A high-byte write made while `mem_busy` is high does not change the committed frame. The value it captured is committed at the first rising edge at which `mem_busy` is sampled low, and not before.
- R4: The page register (0xFF02) keeps wdata[6:0] and ignores bit 7. It takes effect on the next access even while `mem_busy` is high.
- R5: Readback through `cpu_rdata` is combinational on `cpu_addr`. 0xFF00 returns frame bits 7:0. 0xFF01 returns {5'b0, frame bits 10:8}. 0xFF02 returns {1'b0, page}. Any other address returns 0.
- R6: A CPU access in window 0x8000–0x8FFF, 0x9000–0x9FFF or 0xA000–0xAFFF gives `mem_addr` = {F, cpu_addr[11:0]}. F is the committed frame plus 0, 1 or 2 respectively.
- R7: Frame offsets wrap inside the ring from `ring_first` to `ring_last`: F = first + ((frame − first + k) mod (last − first + 1)). This holds for rings of one, two and all 2048 frames.
- R8: A CPU access below 0x8000 gives `mem_addr` = {1'b0, page[6:0], cpu_addr[14:0]}.
- R9: `mem_req` is high for exactly the one cycle after a read or write strobe in a window or in the flat region, with `mem_addr` valid in that cycle. Register addresses and all other addresses raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle |
| cpu_rd | input | 1 | CPU read strobe, one cycle |
| cpu_rdata | output | 8 | Register readback |
| mem_busy | input | 1 | A buffer cycle using the frame counter is in flight |
| ring_first | input | 11 | First frame of the circular region |
| ring_last | input | 11 | Last frame of the circular region |
| mem_req | output | 1 | Buffer access request pulse |
| mem_addr | output | 23 | Buffer byte address |

## Verification
The bench aims at the wrap edge. It places the frame at the last ring slot and one before it, and uses rings of one, two and 2048 frames. A translator that wraps once, or compares against the wrong bound, would give an address outside the ring or one frame off. It writes the low byte alone and reads back, so a design that commits early would show the new value too soon. It holds `mem_busy` high across a high-byte write and probes the readback on both sides of the release edge, which exposes a load that lands early, late or never. A page write made while busy must steer the very next flat access, so a design that wrongly deferred it would show a stale page.

// File: rtl/mfw_pkg.sv
`timescale 1ns/1ps
package mfw_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_WIN  = 2'd1,
    SEL_FLAT = 2'd2
  } sel_e;
endpackage

// File: rtl/mfw_frame_regs.sv
`timescale 1ns/1ps
module mfw_frame_regs #(
  parameter int DW    = 8,
  parameter int FRM_W = 11
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [DW-1:0]    wdata,
  input  logic             mem_busy,
  output logic [FRM_W-1:0] frm_q
);
  localparam int HI_W = FRM_W - DW;

  logic [DW-1:0]    lo_q;
  logic [FRM_W-1:0] pval_q, cand, frm_d;
  logic             pend_q, pend_d, frm_en, pval_en;

  always_comb begin
    cand    = {wdata[HI_W-1:0], lo_q};
    frm_en  = 1'b0;
    frm_d   = cand;
    pval_en = 1'b0;
    pend_d  = pend_q;
    if (wr_hi && !mem_busy) begin
      frm_en = 1'b1;
      pend_d = 1'b0;
    end else if (wr_hi) begin
      pval_en = 1'b1;
      pend_d  = 1'b1;
    end else if (pend_q && !mem_busy) begin
      frm_en = 1'b1;
      frm_d  = pval_q;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      frm_q  <= '0;
      pval_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_lo)   lo_q   <= wdata;
      if (frm_en)  frm_q  <= frm_d;
      if (pval_en) pval_q <= cand;
      pend_q <= pend_d;
    end
  end

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_busy |=> $stable(frm_q)); // R3
  AST_PEND_APPLIED: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_q && !mem_busy && !wr_hi) |=> (frm_q == $past(pval_q))); // R3
  AST_LO_STAGES_ONLY: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_lo && !pend_q) |=> $stable(frm_q)); // R2
endmodule

// File: rtl/mfw_page_reg.sv
`timescale 1ns/1ps
module mfw_page_reg #(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr,
  input  logic [PAGE_W-1:0] wdata,
  output logic [PAGE_W-1:0] page_q
);
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  page_q <= '0;
    else if (wr)  page_q <= wdata;
  end

  AST_PAGE_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_ni)
    wr |=> (page_q == $past(wdata))); // R4
endmodule

// File: rtl/mfw_wrap.sv
`timescale 1ns/1ps
module mfw_wrap #(
  parameter int FRM_W = 11,
  parameter int STEP  = 1
) (
  input  logic [FRM_W-1:0] base,
  input  logic [FRM_W-1:0] first,
  input  logic [FRM_W-1:0] last,
  output logic [FRM_W-1:0] res
);
  localparam int SW = FRM_W + 1;

  logic [SW-1:0] span, acc;

  always_comb begin
    span = {1'b0, last} - {1'b0, first} + SW'(1);
    acc  = {1'b0, base} + SW'(STEP);
    for (int i = 0; i < STEP; i++) begin
      if (acc > {1'b0, last}) acc = acc - span;
    end
  end

  assign res = acc[FRM_W-1:0];

  always_comb begin
    if (first <= last && base >= first && base <= last) begin
      AST_WRAP_IN_RING: assert (acc <= {1'b0, last} && acc >= {1'b0, first}); // R7
    end
  end
endmodule

// File: rtl/mfw_xlate.sv
`timescale 1ns/1ps
module mfw_xlate #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int FRM_W  = 11,
  parameter int OFS_W  = 12,
  parameter int PAGE_W = 7,
  parameter int FLAT_W = 15,
  parameter int NWIN   = 3,
  parameter logic [15:0] WIN_BASE = 16'h8000,
  parameter logic [15:0] REG_BASE = 16'hFF00,
  localparam int MA_W  = (FRM_W + OFS_W > PAGE_W + FLAT_W) ? FRM_W + OFS_W : PAGE_W + FLAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  output logic [DW-1:0]    cpu_rdata,
  input  logic             mem_busy,
  input  logic [FRM_W-1:0] ring_first,
  input  logic [FRM_W-1:0] ring_last,
  output logic             mem_req,
  output logic [MA_W-1:0]  mem_addr
);
  import mfw_pkg::*;

  localparam int TAG_W = AW - OFS_W;

  logic [1:0]        rs_q;
  logic              rst_ni;
  logic [TAG_W-1:0]  win_tag;
  sel_e              sel;
  logic              hit_lo, hit_hi, hit_pg, strobe, req_d, req_q;
  logic [FRM_W-1:0]  frm_q, sel_frm;
  logic [PAGE_W-1:0] page_q;
  logic [MA_W-1:0]   addr_d, addr_q;
  logic [FRM_W-1:0]  win_frm [NWIN];

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // address decode
  assign win_tag = cpu_addr[AW-1:OFS_W] - WIN_BASE[AW-1:OFS_W];
  assign hit_lo  = (cpu_addr == REG_BASE);
  assign hit_hi  = (cpu_addr == REG_BASE + AW'(1));
  assign hit_pg  = (cpu_addr == REG_BASE + AW'(2));
  assign strobe  = cpu_wr | cpu_rd;

  always_comb begin
    if (cpu_addr >= WIN_BASE && win_tag < TAG_W'(NWIN)) sel = SEL_WIN;
    else if (cpu_addr[AW-1:FLAT_W] == '0)              sel = SEL_FLAT;
    else                                                sel = SEL_NONE;
  end

  mfw_frame_regs #(.DW(DW), .FRM_W(FRM_W)) u_frm (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .wr_lo    (cpu_wr & hit_lo),
    .wr_hi    (cpu_wr & hit_hi),
    .wdata    (cpu_wdata),
    .mem_busy (mem_busy),
    .frm_q    (frm_q)
  );

  mfw_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk    (clk),
    .rst_ni (rst_ni),
    .wr     (cpu_wr & hit_pg),
    .wdata  (cpu_wdata[PAGE_W-1:0]),
    .page_q (page_q)
  );

  for (genvar k = 0; k < NWIN; k++) begin : g_win
    mfw_wrap #(.FRM_W(FRM_W), .STEP(k)) u_wrap (
      .base  (frm_q),
      .first (ring_first),
      .last  (ring_last),
      .res   (win_frm[k])
    );
  end

  always_comb begin
    sel_frm = win_frm[0];
    for (int k = 0; k < NWIN; k++) begin
      if (win_tag == TAG_W'(k)) sel_frm = win_frm[k];
    end
  end

  always_comb begin
    req_d = strobe && (sel != SEL_NONE);
    if (sel == SEL_WIN) addr_d = MA_W'({sel_frm, cpu_addr[OFS_W-1:0]});
    else                addr_d = MA_W'({page_q, cpu_addr[FLAT_W-1:0]});
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q <= req_d;
      if (req_d) addr_q <= addr_d;
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = addr_q;

  always_comb begin
    cpu_rdata = '0;
    if (hit_lo)      cpu_rdata = frm_q[DW-1:0];
    else if (hit_hi) cpu_rdata = DW'(frm_q[FRM_W-1:DW]);
    else if (hit_pg) cpu_rdata = DW'(page_q);
  end

  AST_REQ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req |-> $past(strobe)); // R9
  AST_NO_REQ_FOR_REGS: assert property (@(posedge clk) disable iff (!rst_ni)
    (strobe && (hit_lo || hit_hi || hit_pg)) |=> !mem_req); // R9
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && !$past(strobe, 2)) |=> !mem_req || $past(strobe)); // R9
endmodule

// File: tb/mfw_xlate_test.sv
`timescale 1ns/1ps
module mfw_xlate_test;
  localparam logic [15:0] A_LO = 16'hFF00;
  localparam logic [15:0] A_HI = 16'hFF01;
  localparam logic [15:0] A_PG = 16'hFF02;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        cpu_wr, cpu_rd, mem_busy, mem_req;
  logic [10:0] ring_first, ring_last;
  logic [22:0] mem_addr;

  int vec = 0;
  int bad = 0;
  bit done = 0;
  logic [22:0] expq[$];
  logic [10:0] mf;
  logic [6:0]  mp;

  always #2.5 clk = ~clk;

  mfw_xlate uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .mem_busy(mem_busy),
    .ring_first(ring_first), .ring_last(ring_last), .mem_req(mem_req), .mem_addr(mem_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] nxt(input logic [10:0] f, input int k);
    int sp, r;
    sp = int'(ring_last) - int'(ring_first) + 1;
    r  = (int'(f) - int'(ring_first) + k) % sp;
    return 11'(int'(ring_first) + r);
  endfunction

  // monitor: pops expected addresses as requests appear
  always @(posedge clk) begin
    #1;
    if (rst_n && mem_req) begin
      if (expq.size() == 0) check("R9 unexpected request", 32'(mem_addr), 32'h7FFFFFFF);
      else check("R6/R7/R8 address", 32'(mem_addr), 32'(expq.pop_front()));
    end
  end

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [15:0] a, input logic [7:0] e);
    @(negedge clk);
    cpu_addr = a;
    #1 check(req, 32'(cpu_rdata), 32'(e));
  endtask

  task automatic access(input logic [15:0] a, input bit wr, input bit want, input logic [22:0] e);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = 8'hA5; cpu_wr = wr; cpu_rd = !wr;
    if (want) expq.push_back(e);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
    check("R9 request count", 32'(expq.size()), 32'd0);
  endtask

  task automatic set_frame(input logic [10:0] f);
    wr_reg(A_LO, f[7:0]);
    wr_reg(A_HI, {5'b10101, f[10:8]});
    mf = f;
  endtask

  task automatic win(input logic [15:0] a);
    access(a, 1'b0, 1'b1, {nxt(mf, int'(a[15:12]) - 8), a[11:0]});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_wr = 0; cpu_rd = 0; mem_busy = 0;
    ring_first = 11'h500; ring_last = 11'h5FF; mf = '0; mp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_check("R1 lo", A_LO, 8'h00);
    rd_check("R1 hi", A_HI, 8'h00);
    rd_check("R1 page", A_PG, 8'h00);
    check("R1 req", 32'(mem_req), 32'd0);

    // R2 staging
    wr_reg(A_LO, 8'h34);
    rd_check("R2 lo staged only", A_LO, 8'h00);
    rd_check("R2 hi staged only", A_HI, 8'h00);
    wr_reg(A_HI, 8'hF5); mf = 11'h534;
    rd_check("R2 lo commit", A_LO, 8'h34);
    rd_check("R5 hi upper zero", A_HI, 8'h05);
    rd_check("R5 unmapped", 16'hFF07, 8'h00);

    // R6 windows
    win(16'h8123);
    win(16'h9FFF);
    access(16'hA000, 1'b1, 1'b1, {11'h536, 12'h000}); // R6 explicit

    // R4 / R8 page
    wr_reg(A_PG, 8'hFF); mp = 7'h7F;
    rd_check("R4 bit7 dropped", A_PG, 8'h7F);
    access(16'h1234, 1'b0, 1'b1, {1'b0, mp, 15'h1234}); // R8
    access(16'h7FFF, 1'b1, 1'b1, {1'b0, mp, 15'h7FFF}); // R8

    // R9 no requests
    access(16'hB000, 1'b0, 1'b0, '0);
    access(16'hC123, 1'b1, 1'b0, '0);
    access(A_PG, 1'b0, 1'b0, '0);

    // R7 wrap
    set_frame(11'h5FF);
    access(16'h9010, 1'b0, 1'b1, {11'h500, 12'h010}); // R7
    access(16'hA020, 1'b0, 1'b1, {11'h501, 12'h020}); // R7
    set_frame(11'h5FE);
    access(16'hA030, 1'b0, 1'b1, {11'h500, 12'h030}); // R7
    ring_first = 11'h5FF;
    win(16'h9000); win(16'hA000);              // R7 one-frame ring
    ring_first = 11'h5FE; set_frame(11'h5FF);
    access(16'h9004, 1'b0, 1'b1, {11'h5FE, 12'h004}); // R7 two-frame ring
    access(16'hA008, 1'b0, 1'b1, {11'h5FF, 12'h008}); // R7
    ring_first = 11'h000; ring_last = 11'h7FF; set_frame(11'h7FF);
    access(16'h9000, 1'b0, 1'b1, {11'h000, 12'h000}); // R7 full ring
    access(16'hAFFF, 1'b0, 1'b1, {11'h001, 12'hFFF}); // R7
    win(16'h8ABC);

    // R3 deferral
    @(negedge clk); mem_busy = 1'b1;
    wr_reg(A_LO, 8'h10);
    wr_reg(A_HI, 8'h01);
    rd_check("R3 held lo", A_LO, 8'hFF);
    rd_check("R3 held hi", A_HI, 8'h07);
    repeat (3) @(negedge clk);
    rd_check("R3 still held", A_LO, 8'hFF);
    win(16'h8040);                                // R3 old frame used
    wr_reg(A_PG, 8'h22); mp = 7'h22;
    rd_check("R4 page while busy", A_PG, 8'h22);
    access(16'h0005, 1'b0, 1'b1, {1'b0, mp, 15'h0005}); // R4
    cpu_addr = A_LO;
    @(negedge clk); mem_busy = 1'b0;
    #1 check("R3 before release edge", 32'(cpu_rdata), 32'hFF);
    @(posedge clk); #1;
    check("R3 applied lo", 32'(cpu_rdata), 32'h10);
    mf = 11'h110;
    rd_check("R3 applied hi", A_HI, 8'h01);
    win(16'h9100);

    repeat (3) @(negedge clk);
    check("R9 queue drained", 32'(expq.size()), 32'd0);
    finish_run();
  end
endmodule